// File: doc/BRIEF.md
# Shared-Function GPIO Port

This block is a general-purpose I/O port of `N` pins. Each pin owns three configuration bits held in registers: an output-data latch, a direction bit and a pull-enable bit. Per pin, the block works out the pad output enable, the pad output value, the input-buffer enable and the pull-up enable. It arbitrates between plain GPIO use, an alternate digital peripheral and an analog function. When an analog function is enabled it overrides both of the others.

Software reaches the port through a small word-addressed register interface with a single-cycle write strobe and a registered read. Incoming pad levels pass through a two-flop synchroniser before they reach the read path. The direction bit always selects what a port-data read returns, even while a peripheral is driving the pin. A pin whose direction is input and whose input buffer is off reads as 0.

Top module: `gpio_share_port`

## Requirements
- R1: After reset every data, direction and pull-enable bit is 0. With no alternate or analog function enabled, every pad is then undriven (`padOe`=0, `padOut`=0) and has its pull-up off.
- R2: With neither the alternate nor the analog function enabled on a pin, `padOe` equals that pin's direction bit and `padOut` equals its data latch.
- R3: A read of offset 0 returns, per bit, the data latch when the direction bit is 1 and the synchronised pad input when it is 0. Read data appears on `regRdData` in the cycle after the cycle in which `regRdEn` is high.
- R4: `padIbe` is 1 for every pin whose `anaEn` is 0, and 0 for every pin whose `anaEn` is 1.
- R5: With `altEn`=1 and `anaEn`=0 on a pin, `padOe` follows `altOe` and `padOut` follows `altOut`. The offset-0 read source for that pin still follows its direction bit.
- R6: With `anaEn`=1 on a pin, `padOe`=0 and `padOut`=0 whatever `altEn` is. An input-direction bit on such a pin reads as 0.
- R7: `padPu` is 1 only when the pin's pull-enable bit is 1, its `padOe` is 0 and its `anaEn` is 0.
- R8: The data latch can be written while the pin is an input. A later write of 1 to the direction bit puts the preloaded value on `padOut` in the same cycle that `padOe` rises.
- R9: Offsets: 0 is data, 1 is direction and 2 is pull enable. Offsets 1 and 2 read back the value last written to them. A write to offset 3 changes no register, and a read of offset 3 returns 0.
- R10: A change on `padIn` reaches the offset-0 read value of an input pin only after two clock edges. A read captured at the first or second edge after the change still returns the old level; the read captured at the third edge returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Single-cycle write strobe |
| regRdEn | input | 1 | Read request; data valid next cycle |
| regAddr | input | 2 | Word offset (0 data, 1 direction, 2 pull enable) |
| regWrData | input | N | Write data, one bit per pin |
| regRdData | output | N | Registered read data |
| altEn | input | N | Alternate digital function enable per pin |
| altOut | input | N | Alternate function output value |
| altOe | input | N | Alternate function output enable |
| anaEn | input | N | Analog function enable per pin |
| padIn | input | N | Asynchronous pad input levels |
| padOe | output | N | Pad output-buffer enable |
| padOut | output | N | Pad output value |
| padIbe | output | N | Pad input-buffer enable |
| padPu | output | N | Pad pull-up enable |

## Verification
Two things can happen in one cycle: a pin is handed to a peripheral or to the analog function, and software reads that pin's data bit. In that cycle the read source must still follow the direction bit while the pad controls follow the override. The bench provokes this with vectors that set `altEn`, `anaEn`, direction and pad input to different masks across the pins, then reads offset 0. It judges each pad output and the read word against a per-bit model written from the requirements. A second collision, a pad change racing a read, is provoked by issuing back-to-back reads right after the change and checking that exactly the third capture shows the new level.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_PULL = 2'd2;

  typedef enum logic [1:0] {
    RD_DATA = 2'd0,
    RD_DIR  = 2'd1,
    RD_PULL = 2'd2,
    RD_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrPull;
    logic   rdStrobe;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_share_ctrl.sv
module gpio_share_ctrl
  import gpio_share_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobes
);
  logic hitData;
  logic hitDir;
  logic hitPull;

  always_comb begin
    hitData = (regAddr == OFS_DATA);
    hitDir  = (regAddr == OFS_DIR);
    hitPull = (regAddr == OFS_PULL);
  end

  always_comb begin
    strobes.wrData   = regWrEn & hitData;
    strobes.wrDir    = regWrEn & hitDir;
    strobes.wrPull   = regWrEn & hitPull;
    strobes.rdStrobe = regRdEn;
    if (hitData)      strobes.rdSel = RD_DATA;
    else if (hitDir)  strobes.rdSel = RD_DIR;
    else if (hitPull) strobes.rdSel = RD_PULL;
    else              strobes.rdSel = RD_NONE;
  end
endmodule

// File: rtl/gpio_share_dp.sv
module gpio_share_dp
  import gpio_share_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobes,
  input  logic [N-1:0] regWrData,
  output logic [N-1:0] regRdData,
  input  logic [N-1:0] altEn,
  input  logic [N-1:0] altOut,
  input  logic [N-1:0] altOe,
  input  logic [N-1:0] anaEn,
  input  logic [N-1:0] padIn,
  output logic [N-1:0] padOe,
  output logic [N-1:0] padOut,
  output logic [N-1:0] padIbe,
  output logic [N-1:0] padPu,
  output logic [N-1:0] dataBits,
  output logic [N-1:0] dirBits,
  output logic [N-1:0] pullBits
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [N-1:0] dataQ;
  logic [N-1:0] dirQ;
  logic [N-1:0] pullQ;
  logic [N-1:0] syncQ [SYNC_STAGES];
  logic [N-1:0] pinView;
  logic [N-1:0] rdQ;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      pullQ <= '0;
    end else begin
      if (strobes.wrData) dataQ <= regWrData;
      if (strobes.wrDir)  dirQ  <= regWrData;
      if (strobes.wrPull) pullQ <= regWrData;
    end
  end

  // input synchroniser chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= '0;
          else       syncQ[0] <= padIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  // per-pin arbitration
  genvar p;
  generate
    for (p = 0; p < N; p++) begin : gPin
      logic ownedByAna;
      logic ownedByAlt;
      logic oeBit;
      always_comb begin
        ownedByAna = anaEn[p];
        ownedByAlt = altEn[p] & ~anaEn[p];
        if (ownedByAna)      oeBit = 1'b0;
        else if (ownedByAlt) oeBit = altOe[p];
        else                 oeBit = dirQ[p];
        padOe[p] = oeBit;
        if (ownedByAna)      padOut[p] = 1'b0;
        else if (ownedByAlt) padOut[p] = altOut[p];
        else                 padOut[p] = dataQ[p];
        padIbe[p] = ~ownedByAna;
        padPu[p]  = pullQ[p] & ~oeBit & ~ownedByAna;
        if (dirQ[p])         pinView[p] = dataQ[p];
        else if (ownedByAna) pinView[p] = 1'b0;
        else                 pinView[p] = syncQ[LAST][p];
      end
    end
  endgenerate

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (strobes.rdStrobe) begin
      unique case (strobes.rdSel)
        RD_DATA: rdQ <= pinView;
        RD_DIR:  rdQ <= dirQ;
        RD_PULL: rdQ <= pullQ;
        default: rdQ <= '0;
      endcase
    end
  end

  assign regRdData = rdQ;
  assign dataBits  = dataQ;
  assign dirBits   = dirQ;
  assign pullBits  = pullQ;
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_share_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [N-1:0]      regWrData,
  output logic [N-1:0]      regRdData,
  input  logic [N-1:0]      altEn,
  input  logic [N-1:0]      altOut,
  input  logic [N-1:0]      altOe,
  input  logic [N-1:0]      anaEn,
  input  logic [N-1:0]      padIn,
  output logic [N-1:0]      padOe,
  output logic [N-1:0]      padOut,
  output logic [N-1:0]      padIbe,
  output logic [N-1:0]      padPu
);
  strobe_t      strobes;
  logic [N-1:0] dataBits;
  logic [N-1:0] dirBits;
  logic [N-1:0] pullBits;

  gpio_share_ctrl i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  gpio_share_dp #(.N(N), .SYNC_STAGES(2)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .altEn     (altEn),
    .altOut    (altOut),
    .altOe     (altOe),
    .anaEn     (anaEn),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padIbe    (padIbe),
    .padPu     (padPu),
    .dataBits  (dataBits),
    .dirBits   (dirBits),
    .pullBits  (pullBits)
  );
endmodule

// File: rtl/gpio_share_chk.sv
module gpio_share_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         regWrEn,
  input logic         regRdEn,
  input logic [1:0]   regAddr,
  input logic [N-1:0] regWrData,
  input logic [N-1:0] regRdData,
  input logic [N-1:0] altEn,
  input logic [N-1:0] altOe,
  input logic [N-1:0] anaEn,
  input logic [N-1:0] padOe,
  input logic [N-1:0] padOut,
  input logic [N-1:0] padIbe,
  input logic [N-1:0] padPu,
  input logic [N-1:0] dataBits,
  input logic [N-1:0] dirBits,
  input logic [N-1:0] pullBits
);
  p_gpio_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe ^ dirBits) & ~altEn & ~anaEn) == '0);

  p_gpio_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut ^ dataBits) & ~altEn & ~anaEn) == '0);

  p_ibe_r4: assert property (@(posedge clk) disable iff (!rstN)
    padIbe == ~anaEn);

  p_alt_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe ^ altOe) & altEn & ~anaEn) == '0);

  p_ana_kill_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & anaEn) == '0);

  p_pull_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (padPu & (padOe | anaEn | ~pullBits)) == '0);

  p_dir_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd1) |=> regRdData == $past(dirBits));

  p_dir_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1) |=> dirBits == $past(regWrData));

  p_hole_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd3) |=> ($stable(dataBits) && $stable(dirBits) && $stable(pullBits)));
endmodule

bind gpio_share_port gpio_share_chk #(.N(N)) i_gpio_share_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .altEn     (altEn),
  .altOe     (altOe),
  .anaEn     (anaEn),
  .padOe     (padOe),
  .padOut    (padOut),
  .padIbe    (padIbe),
  .padPu     (padPu),
  .dataBits  (dataBits),
  .dirBits   (dirBits),
  .pullBits  (pullBits)
);

// File: tb/test_gpio_share_port.sv
`timescale 1ns/1ps
module test_gpio_share_port;
  localparam int N = 8;
  localparam int NV = 6;
  // fields: dir, data, pull, altEn, altOe, altOut, anaEn, padIn
  localparam logic [63:0] VECS [NV] = '{
    64'hFF_5A_00_00_00_00_00_00,
    64'h00_5A_FF_00_00_00_00_C3,
    64'h0F_33_F0_3C_14_0C_00_99,
    64'hAA_0F_FF_FF_FF_55_81_FF,
    64'h00_FF_FF_00_00_00_F0_FF,
    64'h55_66_AA_0F_00_FF_0C_3C
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [N-1:0] regWrData = '0, regRdData;
  logic [N-1:0] altEn = '0, altOut = '0, altOe = '0, anaEn = '0, padIn = '0;
  logic [N-1:0] padOe, padOut, padIbe, padPu;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_share_port #(.N(N)) i_gpio_share_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .altEn(altEn), .altOut(altOut), .altOe(altOe), .anaEn(anaEn),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padIbe(padIbe), .padPu(padPu)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic regWrite(input logic [1:0] a, input logic [N-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [N-1:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 padOe", padOe, '0);
    check("R1 padOut", padOut, '0);
    check("R1 padPu", padPu, '0);
    regRead(2'd1, rd); check("R1 dir", rd, '0);
    regRead(2'd2, rd); check("R1 pull", rd, '0);

    // vector walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      logic [N-1:0] vDir, vData, vPull, vAltEn, vAltOe, vAltOut, vAna, vIn;
      logic [N-1:0] eOe, eOut, ePu, eRd;
      {vDir, vData, vPull, vAltEn, vAltOe, vAltOut, vAna, vIn} = VECS[v];
      regWrite(2'd0, vData);
      regWrite(2'd1, vDir);
      regWrite(2'd2, vPull);
      altEn = vAltEn; altOe = vAltOe; altOut = vAltOut; anaEn = vAna; padIn = vIn;
      repeat (3) @(negedge clk);
      for (int b = 0; b < N; b++) begin
        if (vAna[b]) begin eOe[b] = 1'b0; eOut[b] = 1'b0; end
        else if (vAltEn[b]) begin eOe[b] = vAltOe[b]; eOut[b] = vAltOut[b]; end
        else begin eOe[b] = vDir[b]; eOut[b] = vData[b]; end
        ePu[b] = vPull[b] & ~eOe[b] & ~vAna[b];
        eRd[b] = vDir[b] ? vData[b] : (vAna[b] ? 1'b0 : vIn[b]);
      end
      check($sformatf("R2/R5/R6 padOe v%0d", v), padOe, eOe);
      check($sformatf("R2/R5/R6 padOut v%0d", v), padOut, eOut);
      check($sformatf("R4 padIbe v%0d", v), padIbe, ~vAna);
      check($sformatf("R7 padPu v%0d", v), padPu, ePu);
      regRead(2'd0, rd);
      check($sformatf("R3/R5/R6 read v%0d", v), rd, eRd);
    end

    // R8 preload while input
    altEn = '0; anaEn = '0;
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'hA5);
    check("R8 still undriven", padOe, 8'h00);
    regWrite(2'd1, 8'hFF);
    check("R8 oe", padOe, 8'hFF);
    check("R8 preloaded out", padOut, 8'hA5);

    // R9 map and hole
    regWrite(2'd2, 8'h3C);
    regWrite(2'd3, 8'h00);
    regRead(2'd0, rd); check("R9 data kept", rd, 8'hA5);
    regRead(2'd1, rd); check("R9 dir kept", rd, 8'hFF);
    regRead(2'd2, rd); check("R9 pull kept", rd, 8'h3C);
    regRead(2'd3, rd); check("R9 hole reads 0", rd, 8'h00);

    // R10 synchroniser lag
    regWrite(2'd1, 8'h00);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'hFF;
    regRead(2'd0, rd); check("R10 edge1 old", rd, 8'h00);
    regRead(2'd0, rd); check("R10 edge2 old", rd, 8'h00);
    regRead(2'd0, rd); check("R10 edge3 new", rd, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule